// File: doc/BRIEF.md
# Delta-Sigma ADC Conversion Sequencer

This block is the digital control for a delta-sigma converter. It makes an ADC clock enable from the system clock and schedules conversions. It times each conversion as a mux settling interval followed by a decimation window. When a conversion finishes, it captures the signed result from the external decimation filter. The filter arithmetic and the analog modulator are not part of this block. The filter's output enters on `result_in`, which must be valid in the cycle in which the last window tick occurs.

Software uses a small register port. It sets the decimation length, a single-ended flag and the last channel of the scan, and it starts a scan that converts channel 0 up to that last channel. Writing the channel field queues one extra conversion of any of 16 channels. The block slips that conversion in after the scan conversion in flight finishes, so it never cuts one short. Scan completions pulse a per-channel DMA request and a shared DMA request. Extra completions pulse an interrupt. Both kinds of completion set an end-of-conversion flag, and reading the high result byte clears that flag.

Top module: `adc_seq_ctrl`

## Requirements
- R1: `adc_tick` is high for exactly one system clock in every 6. All conversion timing is counted in these ticks.
- R2: A conversion lasts N+16 ticks, where cfg[1:0] selects N: 0 gives 64, 1 gives 128, 2 gives 256 and 3 gives 512. Back-to-back completions are therefore (N+16)*6 clocks apart.
- R3: In every conversion, `filt_window` is low during the first 16 ticks (settling) and high during the last N ticks. It changes only on the clock after a tick.
- R4: Writing 1 to bit 0 at address 0 starts a scan that converts channels 0 to cfg[6:4] in rising order. Each scan completion gives a one-clock pulse on `dma_ch[channel]` together with `dma_all`. At most one `dma_ch` bit is ever high.
- R5: A write to address 2 queues an extra conversion of channel wr_data[3:0]. Its completion pulses `irq` for one clock, with no DMA pulse. It runs only after the scan conversion in flight has finished, and it runs before the next scan channel.
- R6: Every completion sets `eoc` in the clock after the final tick. `eoc` is also readable at bit 7 of address 0. A read of address 3 clears it, and a read of address 4 leaves it set.
- R7: The result reads as a 16-bit left-aligned word {result, 2'b00}. Address 3 returns bits 15:8 and address 4 returns bits 7:0. The value 8191 reads as 0x7F/0xFC and -8192 reads as 0x80/0x00.
- R8: When cfg[2] (single-ended) is set, a negative result is stored as 0. A non-negative result is stored unchanged.
- R9: Reading address 2 returns the last converted channel, plus 1 when the value last written to address 2 is below 12 (modulo 16).
- R10: A scan start written while a scan is running, including its final conversion, is ignored.
- R11: After reset, `eoc`, `irq`, `dma_ch`, `dma_all` and `busy` are 0, the status and result reads are 0, and the channel read returns 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Register read strobe; data appears on the next clock |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Registered read data |
| result_in | input | 14 | Two's complement filter output, valid at the final window tick |
| adc_tick | output | 1 | ADC clock enable, once every 6 clocks |
| mux_ch | output | 4 | Channel being converted |
| filt_window | output | 1 | Decimation window active |
| busy | output | 1 | A conversion is in progress |
| eoc | output | 1 | End-of-conversion flag |
| irq | output | 1 | Extra conversion done pulse |
| dma_ch | output | 8 | Per-channel scan completion pulses |
| dma_all | output | 1 | Any scan completion pulse |

## Verification
Scans are run with several pairs of decimation code and end channel, from a single-channel scan up to a four-channel scan, and every decimation code is used. This separates a wrong tick count, a wrong length decode and a wrong channel order. Extra conversions are tried at full positive scale, full negative scale, with a clamped negative value and with a small positive value. Together these cover byte alignment, the single-ended clamp and both sides of the readback rule, using channel 5 (below 12) and channel 13 (above it). Two further tests show that a mid-scan extra request and a repeated start change only the event order they are supposed to change. The first is an extra request made while a scan is running, and the second is a scan start repeated during a scan.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  // register addresses
  localparam int RA_CTRL   = 0;
  localparam int RA_CFG    = 1;
  localparam int RA_CHAN   = 2;
  localparam int RA_RES_HI = 3;
  localparam int RA_RES_LO = 4;

  // decimation length in ADC ticks for a 2-bit code
  function automatic int unsigned decim_len(input logic [1:0] code);
    return 32'd64 << code;
  endfunction
endpackage

// File: rtl/adc_clk_div.sv
module adc_clk_div #(
  parameter int DIV = 6
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = $clog2(DIV);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == CW'(DIV - 1)) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer import adc_seq_pkg::*; #(
  parameter int SETTLE = 16,
  parameter int CNT_W  = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       start,
  input  logic [1:0] decim_code,
  output logic       active,
  output logic       window,
  output logic       done
);
  localparam logic [CNT_W-1:0] SETTLE_C = CNT_W'(SETTLE);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last_q;   // total ticks minus one, fixed at start

  assign done   = active && tick && (cnt == last_q);
  assign window = active && (cnt >= SETTLE_C);

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cnt    <= '0;
      last_q <= '0;
    end else if (start) begin
      active <= 1'b1;
      cnt    <= '0;
      last_q <= SETTLE_C + CNT_W'(decim_len(decim_code)) - 1'b1;
    end else if (active && tick) begin
      if (cnt == last_q) active <= 1'b0;
      else               cnt    <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/adc_sched.sv
module adc_sched #(
  parameter int CH_W  = 4,
  parameter int SEQ_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             seq_go,
  input  logic [SEQ_W-1:0] seq_end,
  input  logic             extra_req,
  input  logic [CH_W-1:0]  extra_ch,
  input  logic             conv_active,
  input  logic             conv_done,
  output logic             start,
  output logic [CH_W-1:0]  start_ch,
  output logic             cur_extra,
  output logic             seq_busy,
  output logic             extra_pend
);
  logic             seq_act;
  logic [SEQ_W-1:0] seq_nxt;
  logic [SEQ_W-1:0] end_q;
  logic [CH_W-1:0]  xch_q;
  logic             slot_free;

  assign slot_free = !conv_active || conv_done;
  assign start     = slot_free && (extra_pend || seq_act);
  assign start_ch  = extra_pend ? xch_q : CH_W'(seq_nxt);
  assign seq_busy  = seq_act || (conv_active && !cur_extra);

  always_ff @(posedge clk) begin
    if (rst) begin
      seq_act    <= 1'b0;
      seq_nxt    <= '0;
      end_q      <= '0;
      xch_q      <= '0;
      extra_pend <= 1'b0;
      cur_extra  <= 1'b0;
    end else begin
      if (start && extra_pend) begin
        extra_pend <= 1'b0;
        cur_extra  <= 1'b1;
      end else if (start) begin
        cur_extra <= 1'b0;
        if (seq_nxt == end_q) seq_act <= 1'b0;
        else                  seq_nxt <= seq_nxt + 1'b1;
      end else if (seq_go && !seq_busy) begin
        seq_act <= 1'b1;
        seq_nxt <= '0;
        end_q   <= seq_end;
      end
      if (extra_req) begin
        extra_pend <= 1'b1;
        xch_q      <= extra_ch;
      end
    end
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl import adc_seq_pkg::*; #(
  parameter int CLK_DIV   = 6,
  parameter int SETTLE    = 16,
  parameter int RES_W     = 14,
  parameter int CH_W      = 4,
  parameter int SEQ_W     = 3,
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 3,
  parameter int CHAN_WRAP = 12,
  parameter int CNT_W     = 10
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [DATA_W-1:0]       wr_data,
  input  logic                    rd_en,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [DATA_W-1:0]       rd_data,
  input  logic [RES_W-1:0]        result_in,
  output logic                    adc_tick,
  output logic [CH_W-1:0]         mux_ch,
  output logic                    filt_window,
  output logic                    busy,
  output logic                    eoc,
  output logic                    irq,
  output logic [(1<<SEQ_W)-1:0]   dma_ch,
  output logic                    dma_all
);
  localparam int N_DMA  = 1 << SEQ_W;
  localparam int WORD_W = 2 * DATA_W;
  localparam int PAD_W  = WORD_W - RES_W;

  logic tick, conv_active, conv_done, st, cur_extra, seq_busy, extra_pend;
  logic [CH_W-1:0]  st_ch;
  logic [1:0]       cfg_decim;
  logic             cfg_se;
  logic [SEQ_W-1:0] cfg_end;
  logic [CH_W-1:0]  chan_wr, last_ch, chan_rb;
  logic [RES_W-1:0] res_q, res_in_c;
  logic [WORD_W-1:0] res_word;
  logic seq_go, extra_req;
  logic unused_wr;

  assign unused_wr = wr_data[DATA_W-1];
  assign seq_go    = wr_en && (wr_addr == ADDR_W'(RA_CTRL)) && wr_data[0];
  assign extra_req = wr_en && (wr_addr == ADDR_W'(RA_CHAN));

  adc_clk_div #(.DIV(CLK_DIV)) u_div (.clk(clk), .rst(rst), .tick(tick));

  adc_conv_timer #(.SETTLE(SETTLE), .CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst(rst), .tick(tick), .start(st), .decim_code(cfg_decim),
    .active(conv_active), .window(filt_window), .done(conv_done));

  adc_sched #(.CH_W(CH_W), .SEQ_W(SEQ_W)) u_sch (
    .clk(clk), .rst(rst), .seq_go(seq_go), .seq_end(cfg_end),
    .extra_req(extra_req), .extra_ch(wr_data[CH_W-1:0]),
    .conv_active(conv_active), .conv_done(conv_done),
    .start(st), .start_ch(st_ch), .cur_extra(cur_extra),
    .seq_busy(seq_busy), .extra_pend(extra_pend));

  assign adc_tick = tick;
  assign busy     = conv_active;
  assign res_in_c = (cfg_se && result_in[RES_W-1]) ? '0 : result_in;
  assign res_word = {res_q, {PAD_W{1'b0}}};
  assign chan_rb  = (chan_wr < CH_W'(CHAN_WRAP)) ? last_ch + 1'b1 : last_ch;

  // configuration and channel field
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_decim <= '0;
      cfg_se    <= 1'b0;
      cfg_end   <= '0;
      chan_wr   <= '0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_W'(RA_CFG)) begin
        cfg_decim <= wr_data[1:0];
        cfg_se    <= wr_data[2];
        cfg_end   <= wr_data[4 +: SEQ_W];
      end
      if (wr_addr == ADDR_W'(RA_CHAN)) chan_wr <= wr_data[CH_W-1:0];
    end
  end

  // conversion bookkeeping and completion events
  always_ff @(posedge clk) begin
    if (rst) begin
      mux_ch  <= '0;
      last_ch <= '0;
      res_q   <= '0;
      eoc     <= 1'b0;
      irq     <= 1'b0;
      dma_all <= 1'b0;
    end else begin
      if (st) mux_ch <= st_ch;
      irq     <= conv_done && cur_extra;
      dma_all <= conv_done && !cur_extra;
      if (conv_done) begin
        res_q   <= res_in_c;
        last_ch <= mux_ch;
        eoc     <= 1'b1;
      end else if (rd_en && rd_addr == ADDR_W'(RA_RES_HI)) begin
        eoc <= 1'b0;
      end
    end
  end

  for (genvar i = 0; i < N_DMA; i++) begin : g_dma
    always_ff @(posedge clk) begin
      if (rst) dma_ch[i] <= 1'b0;
      else     dma_ch[i] <= conv_done && !cur_extra && (mux_ch == CH_W'(i));
    end
  end

  // registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      case (rd_addr)
        ADDR_W'(RA_CTRL):   rd_data <= {eoc, conv_active, seq_busy, extra_pend, {(DATA_W-4){1'b0}}};
        ADDR_W'(RA_CFG):    rd_data <= DATA_W'({cfg_end, 1'b0, cfg_se, cfg_decim});
        ADDR_W'(RA_CHAN):   rd_data <= DATA_W'(chan_rb);
        ADDR_W'(RA_RES_HI): rd_data <= res_word[WORD_W-1:DATA_W];
        ADDR_W'(RA_RES_LO): rd_data <= res_word[DATA_W-1:0];
        default:            rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
  parameter int N_DMA = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             adc_tick,
  input logic             filt_window,
  input logic             busy,
  input logic             eoc,
  input logic             irq,
  input logic [N_DMA-1:0] dma_ch,
  input logic             dma_all
);
  p_tick_gap_r1: assert property (@(posedge clk) disable iff (rst)
    adc_tick |=> !adc_tick);

  p_event_on_tick_r2: assert property (@(posedge clk) disable iff (rst)
    (irq || dma_all) |-> $past(adc_tick));

  p_window_busy_r3: assert property (@(posedge clk) disable iff (rst)
    filt_window |-> busy);

  p_window_steps_r3: assert property (@(posedge clk) disable iff (rst)
    !adc_tick |=> $stable(filt_window));

  p_dma_onehot_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(dma_ch));

  p_dma_any_r4: assert property (@(posedge clk) disable iff (rst)
    (|dma_ch) |-> dma_all);

  p_irq_no_dma_r5: assert property (@(posedge clk) disable iff (rst)
    irq |-> (!dma_all && dma_ch == '0));

  p_irq_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  p_eoc_on_event_r6: assert property (@(posedge clk) disable iff (rst)
    (irq || dma_all) |-> eoc);
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.N_DMA(1 << SEQ_W)) u_chk (
  .clk(clk), .rst(rst), .adc_tick(adc_tick), .filt_window(filt_window),
  .busy(busy), .eoc(eoc), .irq(irq), .dma_ch(dma_ch), .dma_all(dma_all));

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb;
  logic clk = 0, rst = 1;
  logic wr_en = 0, rd_en = 0;
  logic [2:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic [13:0] result_in = 0;
  logic adc_tick, filt_window, busy, eoc, irq, dma_all;
  logic [3:0] mux_ch;
  logic [7:0] dma_ch;

  int errs = 0, checks = 0;
  int cyc = 0, last_tick = -1;
  int w_hi = 0, w_lo = 0;
  int ev_n = 0;
  int ev_kind [64];   // 1 = irq, 0 = dma
  int ev_ch   [64];
  int ev_cyc  [64];
  int ev_hi   [64];
  int ev_lo   [64];
  logic [7:0] rv;

  // {decim code, end channel}
  localparam logic [4:0] SEQ_TAB [0:4] = '{5'b00_011, 5'b01_001, 5'b00_000, 5'b10_000, 5'b11_000};

  always #5 clk = ~clk;

  adc_seq_ctrl u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .result_in(result_in),
    .adc_tick(adc_tick), .mux_ch(mux_ch), .filt_window(filt_window), .busy(busy),
    .eoc(eoc), .irq(irq), .dma_ch(dma_ch), .dma_all(dma_all));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int onehot_idx(input logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return -1;
  endfunction

  // monitor, sampled on the falling edge
  always @(negedge clk) begin
    cyc++;
    if (!rst && adc_tick) begin
      if (last_tick >= 0) chk(cyc - last_tick == 6, "R1 tick spacing", cyc - last_tick, 6);
      last_tick = cyc;
      if (filt_window) w_hi++;
      else if (busy) w_lo++;
    end
    if (!rst && (irq || dma_all) && ev_n < 64) begin
      ev_kind[ev_n] = irq ? 1 : 0;
      ev_ch[ev_n]   = irq ? -1 : onehot_idx(dma_ch);
      ev_cyc[ev_n]  = cyc;
      ev_hi[ev_n]   = w_hi;
      ev_lo[ev_n]   = w_lo;
      ev_n++;
      w_hi = 0;
      w_lo = 0;
    end
    if (cyc > 150000) begin
      errs++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1; rd_addr = a;
    @(negedge clk);
    rd_en = 0;
    d = rd_data;
  endtask

  task automatic wait_ev(input int n);
    int t = 0;
    while (ev_n < n && t < 20000) begin
      @(negedge clk);
      t++;
    end
    chk(ev_n >= n, "wait for completion", ev_n, n);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int base, nlen, endc;
    idle(3);
    @(negedge clk);
    chk(eoc == 0 && irq == 0 && dma_all == 0 && dma_ch == 0 && busy == 0, "R11 reset outputs",
        {eoc, irq, dma_all, busy}, 0);
    rst = 0;
    rd(3'd0, rv); chk(rv == 8'h00, "R11 status after reset", rv, 0);
    rd(3'd3, rv); chk(rv == 8'h00, "R11 result after reset", rv, 0);
    rd(3'd2, rv); chk(rv == 8'h01, "R11 R9 channel read after reset", rv, 1);

    // table-driven scans
    result_in = 14'd1234;
    for (int e = 0; e < 5; e++) begin
      nlen = 64 << SEQ_TAB[e][4:3];
      endc = int'(SEQ_TAB[e][2:0]);
      wr(3'd1, {1'b0, SEQ_TAB[e][2:0], 2'b00, SEQ_TAB[e][4:3]});
      base = ev_n;
      wr(3'd0, 8'h01);
      wait_ev(base + endc + 1);
      idle((nlen + 16) * 6 + 30);
      chk(ev_n == base + endc + 1, "R4 scan completion count", ev_n - base, endc + 1);
      for (int k = 0; k <= endc; k++) begin
        chk(ev_kind[base+k] == 0 && ev_ch[base+k] == k, "R4 scan channel order", ev_ch[base+k], k);
        chk(ev_lo[base+k] == 16, "R3 settle ticks", ev_lo[base+k], 16);
        chk(ev_hi[base+k] == nlen, "R3 window ticks", ev_hi[base+k], nlen);
        if (k > 0)
          chk(ev_cyc[base+k] - ev_cyc[base+k-1] == (nlen + 16) * 6, "R2 conversion period",
              ev_cyc[base+k] - ev_cyc[base+k-1], (nlen + 16) * 6);
      end
    end
    rd(3'd0, rv); chk(rv[7] == 1, "R6 eoc after scan", rv[7], 1);
    rd(3'd4, rv); chk(rv == 8'h48, "R7 low byte 1234", rv, 8'h48);
    rd(3'd3, rv); chk(rv == 8'h13, "R7 high byte 1234", rv, 8'h13);
    rd(3'd0, rv); chk(rv[7] == 0, "R6 eoc cleared by high read", rv[7], 0);

    // extra conversions
    wr(3'd1, 8'h00);
    result_in = 14'h1FFF;
    base = ev_n;
    wr(3'd2, 8'h05);
    wait_ev(base + 1);
    idle(10);
    chk(ev_n == base + 1 && ev_kind[base] == 1, "R5 extra gives irq only", ev_kind[base], 1);
    rd(3'd4, rv); chk(rv == 8'hFC, "R7 low byte 8191", rv, 8'hFC);
    rd(3'd0, rv); chk(rv[7] == 1, "R6 eoc kept by low read", rv[7], 1);
    rd(3'd3, rv); chk(rv == 8'h7F, "R7 high byte 8191", rv, 8'h7F);
    rd(3'd2, rv); chk(rv == 8'h06, "R9 readback below wrap", rv, 6);

    result_in = 14'h2000;
    base = ev_n;
    wr(3'd2, 8'h0D);
    wait_ev(base + 1);
    idle(10);
    rd(3'd3, rv); chk(rv == 8'h80, "R7 high byte -8192", rv, 8'h80);
    rd(3'd4, rv); chk(rv == 8'h00, "R7 low byte -8192", rv, 0);
    rd(3'd2, rv); chk(rv == 8'h0D, "R9 readback at or above wrap", rv, 13);

    wr(3'd1, 8'h04);
    result_in = 14'h3FFB;
    base = ev_n;
    wr(3'd2, 8'h02);
    wait_ev(base + 1);
    idle(10);
    rd(3'd3, rv); chk(rv == 8'h00, "R8 negative clamped high", rv, 0);
    rd(3'd4, rv); chk(rv == 8'h00, "R8 negative clamped low", rv, 0);
    result_in = 14'd100;
    base = ev_n;
    wr(3'd2, 8'h02);
    wait_ev(base + 1);
    idle(10);
    rd(3'd3, rv); chk(rv == 8'h01, "R8 positive kept high", rv, 1);
    rd(3'd4, rv); chk(rv == 8'h90, "R8 positive kept low", rv, 8'h90);

    // extra request during a scan
    wr(3'd1, 8'h30);
    base = ev_n;
    wr(3'd0, 8'h01);
    wait_ev(base + 1);
    wr(3'd2, 8'h09);
    wait_ev(base + 5);
    idle(600);
    chk(ev_n == base + 5, "R5 insertion event count", ev_n - base, 5);
    chk(ev_ch[base] == 0 && ev_ch[base+1] == 1, "R5 scan conversion not aborted", ev_ch[base+1], 1);
    chk(ev_kind[base+2] == 1, "R5 extra inserted after current", ev_kind[base+2], 1);
    chk(ev_ch[base+3] == 2 && ev_ch[base+4] == 3, "R5 scan resumes", ev_ch[base+4], 3);
    for (int k = 1; k < 5; k++)
      chk(ev_cyc[base+k] - ev_cyc[base+k-1] == 480, "R5 R2 spacing with insertion",
          ev_cyc[base+k] - ev_cyc[base+k-1], 480);

    // repeated start ignored
    wr(3'd1, 8'h10);
    base = ev_n;
    wr(3'd0, 8'h01);
    idle(100);
    wr(3'd0, 8'h01);
    wait_ev(base + 2);
    idle(1200);
    chk(ev_n == base + 2, "R10 restart ignored count", ev_n - base, 2);
    chk(ev_ch[base] == 0 && ev_ch[base+1] == 1, "R10 restart ignored order", ev_ch[base+1], 1);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule